// File: doc/BRIEF.md
# AUX Channel Request Framer

This block turns one command from a link controller into the byte stream of an auxiliary-channel request and then interprets the reply that comes back. A command carries a 16-bit target address, a transfer kind (native write, native read, I2C-over-AUX write, I2C-over-AUX read), a byte count, a stop flag for I2C transfers and up to `MAX_PAY` payload bytes. The framer sends a four-byte header on a valid/ready byte stream, followed by any payload. The header holds the address, the command code and a length field.

After the request has gone out, the block takes the reply as a stream of beats. The first beat is the reply status and every later beat is a data byte. Data bytes that fit the caller's expected size are forwarded in order on a separate output stream. The end of every transaction is marked by a one-cycle completion pulse that carries a pass/fail flag. Commands that cannot be framed are refused at once without sending anything. Only one transaction is open at a time.

Top module: `aux_req_framer`

## Requirements
- R1: Every request begins with the target address, low byte first (byte 0 = `cmd_addr[7:0]`, byte 1 = `cmd_addr[15:8]`).
- R2: Byte 2 is the command code in its upper nibble and zero in its lower nibble. `cmd_kind` encodes 0 = native write (code 8), 1 = native read (code 9), 2 = I2C write (code 0), 3 = I2C read (code 1).
- R3: For native transfers, byte 3 is {total request length mod 16, count-1}. The total length is 4+count for a write and 4 for a read. A native write then sends its payload in order, with payload byte i = `cmd_wdata[8i+7:8i]`. A native read sends only the four header bytes.
- R4: A native command with a count of 0 or above `MAX_PAY` is refused. No byte is sent, and `done` is high with `done_ok` low in the cycle after acceptance.
- R5: For I2C transfers, code value 4 is ORed into the command nibble (bit 6 of byte 2) when `cmd_stop` is low. Byte 3 is 0x50 for a write and 0x40 for a read. An I2C write appends the single byte `cmd_wdata[7:0]`, so it sends five bytes. An I2C read sends four bytes.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.
- R7: `cmd_ready` is low from acceptance of a framed command until the cycle after its final reply beat. A `cmd_valid` in that window is ignored and sends nothing.
- R8: The first reply beat is the status. A nonzero status fails the transaction, and none of its data bytes are forwarded.
- R9: With a zero status, each data beat within the expected size appears on `rd_data` with `rd_valid` one cycle after the beat, in arrival order. `done` pulses for one cycle after the beat that has `rsp_last` high, and `done_ok` is then high.
- R10: The expected size is the count for a native read, 1 for an I2C read and 0 for writes. A reply with more data beats than that fails, and the excess bytes are not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Framer idle, command accepted when valid |
| cmd_kind | input | 2 | Transfer kind (see R2) |
| cmd_addr | input | 16 | Target address |
| cmd_len | input | LEN_W | Byte count for native transfers |
| cmd_stop | input | 1 | I2C: last transfer of the I2C transaction |
| cmd_wdata | input | 8*MAX_PAY | Write payload, byte i at bits 8i+7:8i |
| tx_valid | output | 1 | Request byte valid |
| tx_ready | input | 1 | Request byte taken |
| tx_data | output | 8 | Request byte |
| rsp_valid | input | 1 | Reply beat present |
| rsp_data | input | 8 | Reply status (first beat) or data byte |
| rsp_last | input | 1 | Final reply beat |
| rd_valid | output | 1 | Forwarded reply data valid |
| rd_data | output | 8 | Forwarded reply data byte |
| done | output | 1 | One-cycle end-of-transaction pulse |
| done_ok | output | 1 | Transaction outcome, valid with done |

## Verification
Native writes are swept over every count from 1 to 16. This separates the length-nibble wrap at 12 and above from the count-minus-one field and from payload ordering. Half the sweep runs with a pseudo-random `tx_ready` so that stalls fall on header and payload bytes alike. Native reads are swept over every count with replies that are exactly full, one byte over, and carry a nonzero status. These cases separate the buffer-size check from the status check. I2C reads and writes are run with both stop values to isolate the middle-of-transaction bit. Counts of 0 and 17 and commands offered while busy show that nothing is sent when it should not be.

// File: rtl/aux_req_framer.sv
module aux_req_framer #(
  parameter int MAX_PAY = 16,
  parameter int LEN_W   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [1:0]           cmd_kind,
  input  logic [15:0]          cmd_addr,
  input  logic [LEN_W-1:0]     cmd_len,
  input  logic                 cmd_stop,
  input  logic [8*MAX_PAY-1:0] cmd_wdata,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  output logic [7:0]           tx_data,
  input  logic                 rsp_valid,
  input  logic [7:0]           rsp_data,
  input  logic                 rsp_last,
  output logic                 rd_valid,
  output logic [7:0]           rd_data,
  output logic                 done,
  output logic                 done_ok
);

  localparam int IDX_W = $clog2(MAX_PAY + 5);
  localparam logic [1:0] K_NW = 2'd0, K_NR = 2'd1, K_IW = 2'd2, K_IR = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} st_t;

  st_t                  st_q;
  logic [1:0]           kind_q;
  logic [15:0]          addr_q;
  logic [LEN_W-1:0]     len_q;
  logic                 stop_q;
  logic [8*MAX_PAY-1:0] wdata_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 first_q;
  logic                 fail_q;
  logic [LEN_W-1:0]     rcnt_q;

  logic                 accept, reject;
  logic [3:0]           code;
  logic [7:0]           hdr3, pay_byte;
  logic [LEN_W:0]       total;
  logic [LEN_W-1:0]     lm1, bufsz;
  logic [IDX_W-1:0]     nbytes, last_idx, pidx;
  logic [8*MAX_PAY-1:0] pay_sh;
  logic                 beat_fail;

  assign cmd_ready = (st_q == S_IDLE);
  assign tx_valid  = (st_q == S_SEND);
  assign accept    = cmd_valid && cmd_ready;
  assign reject    = !cmd_kind[1] &&
                     (cmd_len == '0 || cmd_len > LEN_W'(MAX_PAY));

  assign total = {1'b0, len_q} + (LEN_W+1)'(4);
  assign lm1   = len_q - LEN_W'(1);
  assign pidx  = idx_q - IDX_W'(4);
  assign pay_sh   = wdata_q >> (8 * pidx);
  assign pay_byte = pay_sh[7:0];

  always_comb begin
    case (kind_q)
      K_NW:    code = 4'h8;
      K_NR:    code = 4'h9;
      K_IW:    code = stop_q ? 4'h0 : 4'h4;
      default: code = stop_q ? 4'h1 : 4'h5;
    endcase
  end

  always_comb begin
    case (kind_q)
      K_NW:    hdr3 = {total[3:0], lm1[3:0]};
      K_NR:    hdr3 = {4'h4, lm1[3:0]};
      K_IW:    hdr3 = 8'h50;
      default: hdr3 = 8'h40;
    endcase
  end

  always_comb begin
    case (kind_q)
      K_NW:    nbytes = IDX_W'(len_q) + IDX_W'(4);
      K_IW:    nbytes = IDX_W'(5);
      default: nbytes = IDX_W'(4);
    endcase
  end
  assign last_idx = nbytes - IDX_W'(1);

  always_comb begin
    case (kind_q)
      K_NR:    bufsz = len_q;
      K_IR:    bufsz = LEN_W'(1);
      default: bufsz = '0;
    endcase
  end

  always_comb begin
    case (idx_q)
      IDX_W'(0): tx_data = addr_q[7:0];
      IDX_W'(1): tx_data = addr_q[15:8];
      IDX_W'(2): tx_data = {code, 4'h0};
      IDX_W'(3): tx_data = hdr3;
      default:   tx_data = pay_byte;
    endcase
  end

  assign beat_fail = first_q ? (rsp_data != 8'h00) : (rcnt_q >= bufsz);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      kind_q  <= K_NW;
      addr_q  <= '0;
      len_q   <= '0;
      stop_q  <= 1'b0;
      wdata_q <= '0;
      idx_q   <= '0;
      first_q <= 1'b0;
      fail_q  <= 1'b0;
      rcnt_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      done     <= 1'b0;
      done_ok  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      case (st_q)
        S_IDLE: if (accept) begin
          if (reject) begin
            done    <= 1'b1;
            done_ok <= 1'b0;
          end else begin
            kind_q  <= cmd_kind;
            addr_q  <= cmd_addr;
            len_q   <= cmd_len;
            stop_q  <= cmd_stop;
            wdata_q <= cmd_wdata;
            idx_q   <= '0;
            first_q <= 1'b1;
            fail_q  <= 1'b0;
            rcnt_q  <= '0;
            st_q    <= S_SEND;
          end
        end
        S_SEND: if (tx_ready) begin
          if (idx_q == last_idx) st_q <= S_WAIT;
          else                   idx_q <= idx_q + IDX_W'(1);
        end
        S_WAIT: if (rsp_valid) begin
          first_q <= 1'b0;
          if (beat_fail) fail_q <= 1'b1;
          if (!first_q && !beat_fail) begin
            rcnt_q <= rcnt_q + LEN_W'(1);
            if (!fail_q) begin
              rd_valid <= 1'b1;
              rd_data  <= rsp_data;
            end
          end
          if (rsp_last) begin
            done    <= 1'b1;
            done_ok <= !(fail_q || beat_fail);
            st_q    <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/aux_req_framer_chk.sv
module aux_req_framer_chk #(
  parameter int MAX_PAY = 16,
  parameter int LEN_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_kind,
  input logic [15:0]      cmd_addr,
  input logic [LEN_W-1:0] cmd_len,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             done,
  input logic             done_ok
);

  // R1
  addr_low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_data == $past(cmd_addr[7:0]));

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !cmd_ready);

  // R4
  oversize_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_kind == 2'd0 && cmd_len > LEN_W'(MAX_PAY)
    |=> done && !done_ok && !tx_valid);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_valid);

endmodule

bind aux_req_framer aux_req_framer_chk #(.MAX_PAY(MAX_PAY), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .done(done), .done_ok(done_ok)
);

// File: tb/sim_aux_req_framer.sv
module sim_aux_req_framer;
  localparam int MAX_PAY = 16;
  localparam int LEN_W   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_kind = '0;
  logic [15:0] cmd_addr = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic cmd_stop = 1'b0;
  logic [8*MAX_PAY-1:0] cmd_wdata = '0;
  logic tx_valid, tx_ready;
  logic [7:0] tx_data;
  logic rsp_valid = 1'b0;
  logic [7:0] rsp_data = '0;
  logic rsp_last = 1'b0;
  logic rd_valid, done, done_ok;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  int txn = 0, rdn = 0, dn = 0;
  logic [7:0] txb [0:31];
  logic [7:0] rdb [0:31];
  logic dok = 1'b0;
  bit stall_en = 1'b0;
  logic [7:0] lfsr = 8'h5b;
  bit hold_pend = 1'b0;
  logic [7:0] hold_val = '0;

  always #4 clk = ~clk;

  aux_req_framer #(.MAX_PAY(MAX_PAY), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_stop(cmd_stop),
    .cmd_wdata(cmd_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .done_ok(done_ok));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input logic [15:0] a, input int i);
    return 8'(int'(a[7:0]) + 7 * i + 3);
  endfunction

  function automatic logic [7:0] rdat(input int len, input int b);
    return 8'(8'hA0 + 5 * b + len);
  endfunction

  initial tx_ready = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) chk(tx_valid && tx_data == hold_val, "R6 hold", int'(tx_data), int'(hold_val));
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tx_ready = stall_en ? lfsr[0] : 1'b1;
      hold_pend = tx_valid && !tx_ready;
      hold_val = tx_data;
      if (tx_valid && tx_ready && txn < 32) begin txb[txn] = tx_data; txn++; end
      if (rd_valid && rdn < 32) begin rdb[rdn] = rd_data; rdn++; end
      if (done) begin dn++; dok = done_ok; end
    end
  end

  task automatic run(input logic [1:0] k, input int len, input bit stp,
                     input logic [15:0] a, input int ndat, input int status,
                     input bit probe);
    logic [7:0] expb [0:31];
    int nexp, bufsz, nfwd, tot;
    logic [3:0] code;
    bit rej, exp_ok;
    rej = (k < 2) && (len == 0 || len > MAX_PAY);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R7 ready when idle", int'(cmd_ready), 1);
    txn = 0; rdn = 0; dn = 0;
    cmd_kind = k; cmd_addr = a; cmd_len = LEN_W'(len); cmd_stop = stp;
    for (int i = 0; i < MAX_PAY; i++) cmd_wdata[8*i +: 8] = pay(a, i);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (rej) begin
      @(negedge clk); @(negedge clk);
      chk(txn == 0, "R4 nothing sent", txn, 0);
      chk(dn == 1 && dok == 1'b0, "R4 refused", dn * 2 + int'(dok), 2);
      return;
    end
    case (k)
      2'd0: code = 4'h8;
      2'd1: code = 4'h9;
      2'd2: code = stp ? 4'h0 : 4'h4;
      default: code = stp ? 4'h1 : 4'h5;
    endcase
    expb[0] = a[7:0];
    expb[1] = a[15:8];
    expb[2] = {code, 4'h0};
    tot = (k == 2'd0) ? 4 + len : 4;
    if (k < 2) expb[3] = {4'(tot), 4'(len - 1)};
    else       expb[3] = (k == 2'd2) ? 8'h50 : 8'h40;
    nexp = 4;
    if (k == 2'd0) begin
      for (int i = 0; i < len; i++) expb[4 + i] = pay(a, i);
      nexp = 4 + len;
    end else if (k == 2'd2) begin
      expb[4] = pay(a, 0);
      nexp = 5;
    end
    while (txn < nexp) @(negedge clk);
    for (int i = 0; i < nexp; i++) begin
      if (i < 2)       chk(txb[i] == expb[i], "R1 address byte", int'(txb[i]), int'(expb[i]));
      else if (i == 2) chk(txb[i] == expb[i], (k < 2) ? "R2 command byte" : "R5 command byte", int'(txb[i]), int'(expb[i]));
      else if (i == 3) chk(txb[i] == expb[i], (k < 2) ? "R3 length byte" : "R5 length byte", int'(txb[i]), int'(expb[i]));
      else             chk(txb[i] == expb[i], (k == 2'd0) ? "R3 payload" : "R5 data byte", int'(txb[i]), int'(expb[i]));
    end
    if (probe) begin
      @(negedge clk);
      chk(cmd_ready == 1'b0, "R7 busy", int'(cmd_ready), 0);
      cmd_kind = 2'd1; cmd_len = LEN_W'(2); cmd_valid = 1'b1;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
      chk(txn == nexp, "R7 command ignored while busy", txn, nexp);
    end else begin
      @(negedge clk);
      chk(txn == nexp, "R3 byte count", txn, nexp);
    end
    for (int b = 0; b <= ndat; b++) begin
      @(negedge clk);
      rsp_valid = 1'b1;
      rsp_data = (b == 0) ? 8'(status) : rdat(len, b);
      rsp_last = (b == ndat);
    end
    @(negedge clk);
    rsp_valid = 1'b0; rsp_last = 1'b0;
    @(negedge clk);
    bufsz = (k == 2'd1) ? len : (k == 2'd3) ? 1 : 0;
    nfwd = (status != 0) ? 0 : ((ndat < bufsz) ? ndat : bufsz);
    exp_ok = (status == 0) && (ndat <= bufsz);
    chk(dn == 1, "R9 one done pulse", dn, 1);
    if (status != 0)        chk(dok == 1'b0, "R8 status fails", int'(dok), 0);
    else if (ndat > bufsz)  chk(dok == 1'b0, "R10 oversize fails", int'(dok), 0);
    else                    chk(dok == 1'b1, "R9 success", int'(dok), 1);
    chk(rdn == nfwd, (status != 0) ? "R8 nothing forwarded" : "R10 forwarded count", rdn, nfwd);
    for (int i = 0; i < nfwd && i < rdn; i++)
      chk(rdb[i] == rdat(len, i + 1), "R9 data order", int'(rdb[i]), int'(rdat(len, i + 1)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1 && tx_valid == 1'b0, "R7 reset idle", int'({cmd_ready, tx_valid}), 2);
    chk(done == 1'b0 && rd_valid == 1'b0, "R9 reset quiet", int'({done, rd_valid}), 0);
    rst_n = 1'b1;
    for (int n = 1; n <= MAX_PAY; n++) begin
      stall_en = (n % 2 == 0);
      run(2'd0, n, 1'b0, 16'(16'h1234 + n * 16'h0111), 0, 0, n == 3);
    end
    stall_en = 1'b0;
    for (int n = 1; n <= MAX_PAY; n++) begin
      run(2'd1, n, 1'b0, 16'(16'h8000 + n * 16'h0a05), n, 0, 1'b0);
      if (n % 4 == 0) run(2'd1, n, 1'b0, 16'(16'h4000 + n), n + 1, 0, 1'b0);
      if (n % 5 == 0) run(2'd1, n, 1'b0, 16'(16'h2000 + n), n, 8'h02, 1'b0);
    end
    run(2'd1, 6, 1'b0, 16'h0abc, 3, 0, 1'b1);
    for (int s = 0; s < 2; s++) begin
      stall_en = (s == 1);
      run(2'd2, 1, s[0], 16'h0050, 0, 0, 1'b0);
      run(2'd3, 1, s[0], 16'h0050, 1, 0, 1'b0);
      run(2'd3, 1, s[0], 16'h00a0, 2, 0, 1'b0);
      run(2'd3, 1, s[0], 16'h00a0, 1, 8'h01, 1'b0);
    end
    stall_en = 1'b0;
    run(2'd0, 4, 1'b0, 16'h0300, 1, 0, 1'b0);
    run(2'd0, 17, 1'b0, 16'h0400, 0, 0, 1'b0);
    run(2'd0, 0, 1'b0, 16'h0401, 0, 0, 1'b0);
    run(2'd1, 17, 1'b0, 16'h0402, 0, 0, 1'b0);
    run(2'd1, 2, 1'b1, 16'h0403, 2, 0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule